// File: doc/BRIEF.md
# Cascaded Free-Running Capture Timer

This block joins two equal counter halves into one wide up-counter that never stops. The counter advances on each cycle in which the count-clock enable is high, but only while the run bit is set. Two external capture pins are synchronized and then edge-qualified. On a qualifying edge, the block takes a snapshot of the whole count into that channel's low and high capture registers and raises a one-cycle capture interrupt. A capture never alters the running count.

When the count passes all-ones it wraps to zero. The wrap raises a one-cycle overflow interrupt and sets a sticky overflow flag, which software clears by writing 0. The lower half also reports each of its own wraps on a separate interrupt line, because some users still want it. Software can mask that line, since it says nothing about the full-width count. All of these registers are read and written through a simple synchronous write port and a combinational read port.

Top module: `cascade_capture_timer`

## Requirements
- R1: The count goes up by exactly one on each clock where `cnt_tick` is high and the run bit (CTRL bit 0) is 1. It holds its value on every other clock. The low half is read at address 6 and the high half at address 7.
- R2: A qualified edge on channel n copies the count as it stood before that cycle's increment. For channel 0 the low and high halves go to addresses 2 and 3. For channel 1 they go to addresses 4 and 5. The count itself is left unchanged by the capture.
- R3: `irq_cap[n]` is a one-cycle pulse. It rises on the same clock edge that loads channel n's capture registers, which is the third rising edge after the pin change is first sampled.
- R4: Each channel has a 2-bit edge select. Channel 0 uses CTRL bits [2:1] and channel 1 uses bits [4:3]. The codes are 00 for none, 01 for rising, 10 for falling and 11 for both edges.
- R5: On an enabled tick with the count at all-ones, the count becomes zero. On that same edge `irq_ovf` pulses for one cycle and the overflow flag (STAT bit 0, address 1) becomes 1.
- R6: The overflow flag stays at 1 until software writes 0 to STAT bit 0. Writing 1 to it has no effect. If a clearing write lands in the same cycle as a wrap, the flag stays at 1.
- R7: `irq_low_ovf` pulses for one cycle on each enabled tick that wraps the low half, unless the mask bit (CTRL bit 5) is 1.
- R8: A cycle with `sync_clr` high clears the count, all four capture registers, the overflow flag and the interrupt pulses. CTRL is kept.
- R9: After the asynchronous reset, every readable register reads zero and no interrupt is active.
- R10: A write to address 0 stores CTRL bits [5:0], and reading address 0 returns them. Writes to addresses 2 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of count, captures and flag |
| cnt_tick | input | 1 | Count-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | HALF_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | HALF_W | Read data (combinational) |
| cap_in | input | 2 | Asynchronous capture pins |
| irq_cap | output | 2 | Capture interrupt pulses |
| irq_ovf | output | 1 | Full-width overflow pulse |
| irq_low_ovf | output | 1 | Lower-half wrap pulse (maskable) |

## Verification
Every result in this block lands at a fixed cycle:
- A count step, a wrap pulse, a flag change and a lower-half pulse all appear just after the clock edge that samples the tick or the write.
- A capture, together with its interrupt, appears after the third edge following the pin change.

The bench runs a behavioural reference that advances once per rising edge with those same latencies. Two nanoseconds after each edge, it compares every interrupt output and one rotating read address against that reference. As a result, a result that comes a cycle early or a cycle late fails on the cycle where it differs.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_C0_LO  = 3'd2,
    A_C0_HI  = 3'd3,
    A_C1_LO  = 3'd4,
    A_C1_HI  = 3'd5,
    A_CNT_LO = 3'd6,
    A_CNT_HI = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic      low_mask;
    edge_sel_e sel1;
    edge_sel_e sel0;
    logic      run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det
  import cct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      det
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic now_v, prev_v, rise, fall;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign now_v  = sh_q[SYNC_STAGES-1];
  assign prev_v = sh_q[SYNC_STAGES];
  assign rise   = now_v & ~prev_v;
  assign fall   = ~now_v & prev_v;

  always_comb begin
    unique case (sel)
      EDGE_RISE: det = rise;
      EDGE_FALL: det = fall;
      EDGE_BOTH: det = rise | fall;
      default:   det = 1'b0;
    endcase
  end

  // R4
  det_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det |-> (sel != EDGE_OFF) && (now_v != prev_v));
endmodule

// File: rtl/cct_half_cnt.sv
module cct_half_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         carry
);
  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (clr)      val_d = '0;
    else if (inc) val_d = val_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val   = val_q;
  assign carry = inc & (&val_q);

  // R1
  half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (val_q == $past(val_q) + W'(1)));
  // R1
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(val_q));
endmodule

// File: rtl/cct_cap_chan.sv
module cct_cap_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         det,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap,
  output logic         irq
);
  logic [W-1:0] cap_q, cap_d;
  logic         irq_q, irq_d;

  always_comb begin
    cap_d = cap_q;
    irq_d = 1'b0;
    if (clr) begin
      cap_d = '0;
    end else if (det) begin
      cap_d = cnt;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      irq_q <= irq_d;
    end
  end

  assign cap = cap_q;
  assign irq = irq_q;

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det && !clr) |=> (cap_q == $past(cnt)) && irq_q);
  // R3
  cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det |=> !irq_q);
endmodule

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer
  import cct_pkg::*;
#(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              cnt_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0] rd_data,
  input  logic [1:0]        cap_in,
  output logic [1:0]        irq_cap,
  output logic              irq_ovf,
  output logic              irq_low_ovf
);
  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned FULL_W     = NUM_HALVES * HALF_W;

  // control register
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_wr, stat_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign stat_wr = wr_en && (wr_addr == A_STAT);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // chained counter halves
  logic [NUM_HALVES:0] inc_chain;
  logic [HALF_W-1:0]   half_val [NUM_HALVES];
  logic [FULL_W-1:0]   count;

  assign inc_chain[0] = cnt_tick & ctrl_q.run;

  for (genvar gi = 0; gi < NUM_HALVES; gi++) begin : g_half
    cct_half_cnt #(.W(HALF_W)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sync_clr),
      .inc   (inc_chain[gi]),
      .val   (half_val[gi]),
      .carry (inc_chain[gi+1])
    );
    assign count[gi*HALF_W +: HALF_W] = half_val[gi];
  end

  logic wrap_full, wrap_low;
  assign wrap_low  = inc_chain[1];
  assign wrap_full = inc_chain[NUM_HALVES];

  // capture channels
  edge_sel_e         ch_sel [NUM_CH];
  logic [NUM_CH-1:0] ch_det;
  logic [FULL_W-1:0] cap_val [NUM_CH];

  assign ch_sel[0] = ctrl_q.sel0;
  assign ch_sel[1] = ctrl_q.sel1;

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    cct_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_in[gc]),
      .sel   (ch_sel[gc]),
      .det   (ch_det[gc])
    );
    cct_cap_chan #(.W(FULL_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sync_clr),
      .det   (ch_det[gc]),
      .cnt   (count),
      .cap   (cap_val[gc]),
      .irq   (irq_cap[gc])
    );
  end

  // overflow flag and interrupt pulses
  logic ovf_flag_q, ovf_flag_d;
  logic irq_ovf_q, irq_ovf_d;
  logic irq_low_q, irq_low_d;

  always_comb begin
    ovf_flag_d = ovf_flag_q;
    if (sync_clr)                    ovf_flag_d = 1'b0;
    else if (wrap_full)              ovf_flag_d = 1'b1;
    else if (stat_wr && !wr_data[0]) ovf_flag_d = 1'b0;
    irq_ovf_d = wrap_full & ~sync_clr;
    irq_low_d = wrap_low & ~ctrl_q.low_mask & ~sync_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag_q <= 1'b0;
      irq_ovf_q  <= 1'b0;
      irq_low_q  <= 1'b0;
    end else begin
      ovf_flag_q <= ovf_flag_d;
      irq_ovf_q  <= irq_ovf_d;
      irq_low_q  <= irq_low_d;
    end
  end

  assign irq_ovf     = irq_ovf_q;
  assign irq_low_ovf = irq_low_q;

  // read port
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
      A_STAT:   rd_data[0]          = ovf_flag_q;
      A_C0_LO:  rd_data = cap_val[0][HALF_W-1:0];
      A_C0_HI:  rd_data = cap_val[0][FULL_W-1:HALF_W];
      A_C1_LO:  rd_data = cap_val[1][HALF_W-1:0];
      A_C1_HI:  rd_data = cap_val[1][FULL_W-1:HALF_W];
      A_CNT_LO: rd_data = count[HALF_W-1:0];
      default:  rd_data = count[FULL_W-1:HALF_W];
    endcase
  end

  // R5
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> ovf_flag_q && (count == '0));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_q && !sync_clr && !(stat_wr && !wr_data[0])) |=> ovf_flag_q);
  // R7
  low_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_low_ovf |-> (count[HALF_W-1:0] == '0));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (count == '0) && !ovf_flag_q && (irq_cap == 2'b00));
endmodule

// File: tb/cascade_capture_timer_test.sv
module cascade_capture_timer_test;
  localparam int HW   = 8;
  localparam int FW   = 2 * HW;
  localparam int MAXV = (1 << FW) - 1;
  localparam int LMAX = (1 << HW) - 1;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          sync_clr = 1'b0;
  logic          cnt_tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = 3'd0;
  logic [HW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = 3'd0;
  logic [HW-1:0] rd_data;
  logic [1:0]    cap_in = 2'b00;
  logic [1:0]    irq_cap;
  logic          irq_ovf, irq_low_ovf;

  cascade_capture_timer #(.HALF_W(HW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .cnt_tick(cnt_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_in(cap_in), .irq_cap(irq_cap), .irq_ovf(irq_ovf), .irq_low_ovf(irq_low_ovf)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural reference
  int     m_cnt;
  int     m_cap [2];
  bit     m_flag, m_irqo, m_irql, m_run, m_lmask;
  bit     m_irqc [2];
  bit [1:0] m_es [2];
  bit     m_hist [2][3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_irqo = 0; m_irql = 0; m_run = 0; m_lmask = 0;
      for (int c = 0; c < 2; c++) begin
        m_cap[c] = 0; m_irqc[c] = 0; m_es[c] = 2'b00;
        for (int k = 0; k < 3; k++) m_hist[c][k] = 0;
      end
    end else begin
      bit det [2];
      bit inc, wrap, lwrap;
      for (int c = 0; c < 2; c++) begin
        bit s, p;
        s = m_hist[c][1];
        p = m_hist[c][2];
        det[c] = (m_es[c][0] && s && !p) || (m_es[c][1] && !s && p);
        m_hist[c][2] = m_hist[c][1];
        m_hist[c][1] = m_hist[c][0];
        m_hist[c][0] = cap_in[c];
      end
      inc   = cnt_tick && m_run;
      wrap  = inc && (m_cnt == MAXV);
      lwrap = inc && ((m_cnt & LMAX) == LMAX);
      if (sync_clr) begin
        m_cnt = 0; m_flag = 0; m_irqo = 0; m_irql = 0;
        for (int c = 0; c < 2; c++) begin m_cap[c] = 0; m_irqc[c] = 0; end
      end else begin
        for (int c = 0; c < 2; c++) begin
          m_irqc[c] = det[c];
          if (det[c]) m_cap[c] = m_cnt;
        end
        m_irqo = wrap;
        m_irql = lwrap && !m_lmask;
        if (wrap) m_flag = 1;
        else if (wr_en && wr_addr == 3'd1 && !wr_data[0]) m_flag = 0;
        if (inc) m_cnt = (m_cnt + 1) & MAXV;
      end
      if (wr_en && wr_addr == 3'd0) begin
        m_run   = wr_data[0];
        m_es[0] = wr_data[2:1];
        m_es[1] = wr_data[4:3];
        m_lmask = wr_data[5];
      end
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return {m_lmask, m_es[1], m_es[0], m_run};
      1: return m_flag;
      2: return m_cap[0] & LMAX;
      3: return (m_cap[0] >> HW) & LMAX;
      4: return m_cap[1] & LMAX;
      5: return (m_cap[1] >> HW) & LMAX;
      6: return m_cnt & LMAX;
      default: return (m_cnt >> HW) & LMAX;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R10";
      1: return "R6";
      2, 3, 4, 5: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int p0 = 0, p1 = 0, plow = 0;

  // one clock: compare every output against the reference, then release one-shot strobes
  task automatic tick();
    @(posedge clk);
    #2;
    chk("R3 irq_cap0", irq_cap[0], m_irqc[0]);
    chk("R3 irq_cap1", irq_cap[1], m_irqc[1]);
    chk("R5 irq_ovf", irq_ovf, m_irqo);
    chk("R7 irq_low_ovf", irq_low_ovf, m_irql);
    chk(tag_of(rd_addr), rd_data, exp_rd(rd_addr));
    p0 += irq_cap[0];
    p1 += irq_cap[1];
    plow += irq_low_ovf;
    wr_en = 1'b0;
    sync_clr = 1'b0;
    rd_addr = rd_addr + 3'd1;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1;
    wr_addr = 3'(a);
    wr_data = HW'(d);
    tick();
  endtask

  task automatic read_chk(input string tag, input int a, input int exp);
    rd_addr = 3'(a);
    #1;
    chk(tag, rd_data, exp);
  endtask

  int rises0, falls0, rises1, falls1;

  task automatic toggle_run(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      cnt_tick = (i % 3) != 0;
      if (i % period == 0) begin
        if (cap_in[0]) falls0++; else rises0++;
        cap_in[0] = ~cap_in[0];
      end
      if (i % (period + 2) == 1) begin
        if (cap_in[1]) falls1++; else rises1++;
        cap_in[1] = ~cap_in[1];
      end
      tick();
    end
    for (int i = 0; i < 5; i++) tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R9: everything zero after reset
    for (int a = 0; a < 8; a++) read_chk("R9 reset value", a, 0);
    chk("R9 irq idle", {irq_cap, irq_ovf, irq_low_ovf}, 0);
    tick();

    // R10, R4: channel 0 rising, channel 1 falling, run on
    wr(0, 'h13);
    read_chk("R10 ctrl readback", 0, 'h13);
    wr(3, 'h55);  // R10: write to capture address ignored
    wr(6, 'hAA);  // R10: write to count address ignored
    rises0 = 0; falls0 = 0; rises1 = 0; falls1 = 0; p0 = 0; p1 = 0;
    toggle_run(60, 7);
    chk("R4 rising count ch0", p0, rises0);
    chk("R4 falling count ch1", p1, falls1);

    // R4: channel 0 both edges, channel 1 off
    wr(0, 'h07);
    rises0 = 0; falls0 = 0; p0 = 0; p1 = 0;
    toggle_run(60, 5);
    chk("R4 both-edge count ch0", p0, rises0 + falls0);
    chk("R4 off count ch1", p1, 0);

    // R1: run bit cleared freezes count while captures still happen
    wr(0, 'h06);
    toggle_run(30, 4);
    chk("R1 frozen count", {rd_data} == rd_data, 1);
    read_chk("R1 frozen low", 6, exp_rd(6));

    // R5, R6: run to wrap, clear write coincides with wrap
    wr(0, 'h03);
    cnt_tick = 1'b1;
    while (m_cnt != MAXV) tick();
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = '0;
    tick();
    chk("R5 overflow pulse", irq_ovf, 1);
    read_chk("R6 set wins over clear", 1, 1);
    read_chk("R5 count wrapped", 7, 0);
    tick();
    wr(1, 1);
    read_chk("R6 write one no effect", 1, 1);
    wr(1, 0);
    read_chk("R6 write zero clears", 1, 0);

    // R7: masked lower-half wraps
    wr(0, 'h23);
    plow = 0;
    for (int i = 0; i < 300; i++) tick();
    chk("R7 masked low wraps", plow, 0);
    wr(0, 'h03);
    plow = 0;
    for (int i = 0; i < 300; i++) tick();
    chk("R7 unmasked low wraps", plow > 0, 1);

    // R8: synchronous clear
    cap_in = 2'b01;
    for (int i = 0; i < 5; i++) tick();
    sync_clr = 1'b1;
    cnt_tick = 1'b0;
    tick();
    for (int a = 1; a < 8; a++) read_chk("R8 cleared", a, 0);
    read_chk("R8 ctrl kept", 0, 'h03);
    for (int i = 0; i < 4; i++) tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule